// File: doc/BRIEF.md
# Frame-Gated System Reset Sequencer

This block owns the system reset of a serially programmed display driver that also scans a key matrix. It takes a single-cycle power-fail pulse from an analog supply monitor, an active-low reset pin from the board, and the chip-enable strobe of the serial port. Alongside the strobe it takes a frame identifier and a frame-valid flag from the serial logic. From these it produces the internal system reset, a display enable, a key-scan enable and a clear for the key-data register.

A power event puts the chip in reset. Reset is then held until every serial frame of the configuration set has been delivered and the pin is high. The set has four frames: three carry segment data and one carries control. A scoreboard with one bit per frame records each delivered frame. Release comes on the chip-enable falling edge that completes the set, not on a timer. On its own, the pin can reset the chip at any time. Releasing the pin does not require the frames to be sent again unless a power event is still pending.

The chip-enable and reset pins are asynchronous to the clock and pass through two-flop synchronizers. The power-fail pulse and the frame identifier and valid flag are taken as synchronous to the clock. The identifier and valid flag must stay stable for at least three clock cycles after chip enable falls.

Top module: `sysreset_seq`

## Requirements
- R1: While `sys_reset` is 1, `disp_en` is 0, `scan_en` is 0 and `key_clr` is 1.
- R2: While `sys_reset` is 0, `disp_en` is 1, `scan_en` is 1 and `key_clr` is 0.
- R3: A one-cycle `pfail_pulse` sets `sys_reset` to 1 on the next rising clock edge, whatever level `ext_rst_n` has. The same pulse empties the frame scoreboard, so frames delivered before it no longer count.
- R4: After a power event, `sys_reset` stays 1 until frames with identifiers 0, 1, 2 and 3 have each ended with `frame_valid` high. Frames with `frame_valid` low are ignored. Repeated frames and any arrival order are accepted.
- R5: The release happens on the chip-enable falling edge that completes the set. The outputs change on the third rising clock edge after `ce` falls.
- R6: If `ext_rst_n` is low when the set completes, `sys_reset` stays 1. It is released on the third rising edge after the pin goes high.
- R7: With no power event pending, driving `ext_rst_n` low sets `sys_reset` on the third rising edge after the pin falls. Driving it high clears `sys_reset` on the third rising edge after the pin rises, and no frames are needed.
- R8: After the asynchronous `rst_n` is released, the block behaves as after a power event. `sys_reset` is 1 and all four frames are required.
- R9: While released with no power event pending, frames on the serial port leave all four outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flops, released synchronously |
| pfail_pulse | input | 1 | One-cycle power-fail event, synchronous to `clk` |
| ext_rst_n | input | 1 | Active-low external reset pin, asynchronous |
| ce | input | 1 | Serial chip-enable strobe, asynchronous; a frame ends on its falling edge |
| frame_id | input | 2 | Identifier of the frame ending on this strobe (0 to 2 segment data, 3 control) |
| frame_valid | input | 1 | The ending frame was received complete |
| sys_reset | output | 1 | Internal system reset, active high |
| disp_en | output | 1 | Display enable |
| scan_en | output | 1 | Key-scan enable |
| key_clr | output | 1 | Holds the key-data register at zero |

## Verification
A power-fail pulse reaches the outputs one edge after it is sampled. A pin edge on `ce` or `ext_rst_n` takes three edges: two synchronizer stages and then the output register. The bench drives every input on the falling clock edge and samples one time unit after a rising edge. For each timed transition it checks that the outputs still hold their old value after the second rising edge and have changed after the third. The rules that outputs must not move are checked by holding the sample for several cycles after a stimulus: a lone power-up frame, an invalid frame, a frame sent during normal operation, or a set completed while the pin is low.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int unsigned DEF_NUM_FRAMES  = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RESET_VAL;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RESET_VAL;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/frame_scoreboard.sv
module frame_scoreboard #(
  parameter int unsigned NUM_FRAMES = 4,
  localparam int unsigned ID_W = sysrst_pkg::id_width(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_s,
  input  logic                  frame_valid,
  input  logic [ID_W-1:0]       frame_id,
  input  logic                  clear,
  output logic                  ce_fall,
  output logic                  set_full,
  output logic [NUM_FRAMES-1:0] sb
);
  logic                  ce_d_q;
  logic [NUM_FRAMES-1:0] sb_q, sb_d, hit, merged;

  assign ce_fall = ce_d_q & ~ce_s;

  always_comb begin
    hit = '0;
    if (ce_fall && frame_valid && (int'(frame_id) < NUM_FRAMES))
      hit[frame_id] = 1'b1;
    merged   = sb_q | hit;
    sb_d     = clear ? '0 : merged;
    set_full = ~clear & ce_fall & (&merged);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d_q <= 1'b0;
      sb_q   <= '0;
    end else begin
      ce_d_q <= ce_s;
      sb_q   <= sb_d;
    end
  end

  assign sb = sb_q;
endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pfail_pulse,
  input  logic set_full,
  input  logic ext_s,
  output logic por_pending,
  output logic rst_out
);
  logic pend_q, pend_d, rst_q, rst_d;

  always_comb begin
    pend_d = pend_q;
    if (pfail_pulse)   pend_d = 1'b1;
    else if (set_full) pend_d = 1'b0;
    rst_d = pend_d | ~ext_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      rst_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      rst_q  <= rst_d;
    end
  end

  assign por_pending = pend_q;
  assign rst_out     = rst_q;
endmodule

// File: rtl/sysreset_seq.sv
module sysreset_seq #(
  parameter int unsigned NUM_FRAMES  = sysrst_pkg::DEF_NUM_FRAMES,
  parameter int unsigned SYNC_STAGES = sysrst_pkg::DEF_SYNC_STAGES,
  localparam int unsigned ID_W = sysrst_pkg::id_width(NUM_FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pfail_pulse,
  input  logic            ext_rst_n,
  input  logic            ce,
  input  logic [ID_W-1:0] frame_id,
  input  logic            frame_valid,
  output logic            sys_reset,
  output logic            disp_en,
  output logic            scan_en,
  output logic            key_clr
);
  logic                  ext_s, ce_s, ce_fall, set_full, por_pending, rst_int;
  logic [NUM_FRAMES-1:0] sb;

  sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .d_async(ext_rst_n), .q_sync(ext_s)
  );

  sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_ce (
    .clk(clk), .rst_n(rst_n), .d_async(ce), .q_sync(ce_s)
  );

  frame_scoreboard #(.NUM_FRAMES(NUM_FRAMES)) u_sb (
    .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .frame_valid(frame_valid),
    .frame_id(frame_id), .clear(pfail_pulse), .ce_fall(ce_fall),
    .set_full(set_full), .sb(sb)
  );

  reset_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pfail_pulse(pfail_pulse), .set_full(set_full),
    .ext_s(ext_s), .por_pending(por_pending), .rst_out(rst_int)
  );

  assign sys_reset = rst_int;
  assign key_clr   = rst_int;
  assign disp_en   = ~rst_int;
  assign scan_en   = ~rst_int;
endmodule

// File: rtl/sysreset_seq_chk.sv
module sysreset_seq_chk #(
  parameter int unsigned NUM_FRAMES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pfail_pulse,
  input logic                  sys_reset,
  input logic                  ext_s,
  input logic                  ce_fall,
  input logic                  por_pending,
  input logic [NUM_FRAMES-1:0] sb
);
  p_pfail_resets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_pulse |=> (sys_reset && (sb == '0)));

  p_full_before_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_pending) |-> (&sb));

  p_release_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_pending) |-> $past(ce_fall));

  p_pin_low_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_s |=> sys_reset);

  p_free_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_s && !por_pending && !pfail_pulse) |=> !sys_reset);
endmodule

bind sysreset_seq sysreset_seq_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pfail_pulse(pfail_pulse), .sys_reset(sys_reset),
  .ext_s(ext_s), .ce_fall(ce_fall), .por_pending(por_pending), .sb(sb)
);

// File: tb/sysreset_seq_bench.sv
module sysreset_seq_bench;
  logic       clk, rst_n, pfail_pulse, ext_rst_n, ce, frame_valid;
  logic [1:0] frame_id;
  logic       sys_reset, disp_en, scan_en, key_clr;
  int         checks = 0;
  int         errors = 0;

  sysreset_seq u_sysreset_seq (
    .clk(clk), .rst_n(rst_n), .pfail_pulse(pfail_pulse), .ext_rst_n(ext_rst_n),
    .ce(ce), .frame_id(frame_id), .frame_valid(frame_valid),
    .sys_reset(sys_reset), .disp_en(disp_en), .scan_en(scan_en), .key_clr(key_clr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic exp_rst, input string tag);
    checks++;
    if (sys_reset !== exp_rst || disp_en !== ~exp_rst ||
        scan_en !== ~exp_rst || key_clr !== exp_rst) begin
      errors++;
      $display("FAIL %s: rst=%b disp=%b scan=%b clr=%b, expected rst=%b disp=%b scan=%b clr=%b",
               tag, sys_reset, disp_en, scan_en, key_clr,
               exp_rst, ~exp_rst, ~exp_rst, exp_rst);
    end
  endtask

  // After an input change on a falling edge: old value after 2 rising edges, new after 3.
  task automatic expect_change3(input logic old_v, input string tag);
    repeat (2) @(posedge clk);
    #1 chk(old_v, {tag, " (before 3rd edge)"});
    @(posedge clk);
    #1 chk(~old_v, {tag, " (at 3rd edge)"});
  endtask

  task automatic send_frame(input int id, input logic v);
    @(negedge clk);
    frame_id = id[1:0]; frame_valid = v; ce = 1'b1;
    repeat (3) @(negedge clk);
    ce = 1'b0;
    repeat (4) @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic send_last_timed(input int id, input string tag);
    @(negedge clk);
    frame_id = id[1:0]; frame_valid = 1'b1; ce = 1'b1;
    repeat (3) @(negedge clk);
    ce = 1'b0;
    expect_change3(1'b1, tag);
    repeat (2) @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic pulse_pfail();
    @(negedge clk); pfail_pulse = 1'b1;
    @(negedge clk); pfail_pulse = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pfail_pulse = 1'b0; ext_rst_n = 1'b1; ce = 1'b0;
    frame_id = '0; frame_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(1'b1, "R8 R1 reset state after rst_n");
  endtask

  task automatic t_power_up();
    send_frame(2, 1'b1); send_frame(0, 1'b1); send_frame(1, 1'b1);
    repeat (4) @(negedge clk);
    chk(1'b1, "R4 three of four frames");
    send_frame(3, 1'b0);
    repeat (4) @(negedge clk);
    chk(1'b1, "R4 invalid control frame ignored");
    send_last_timed(3, "R5 release on completing ce fall");
    #2 chk(1'b0, "R2 outputs released");
  endtask

  task automatic t_ext_normal();
    @(negedge clk); ext_rst_n = 1'b0;
    expect_change3(1'b0, "R7 pin low asserts reset");
    repeat (5) @(negedge clk);
    chk(1'b1, "R1 outputs while pin low");
    ext_rst_n = 1'b1;
    expect_change3(1'b1, "R7 pin high releases without frames");
  endtask

  task automatic t_normal_frames();
    send_frame(0, 1'b1); send_frame(3, 1'b1);
    repeat (3) @(negedge clk);
    chk(1'b0, "R9 frames in normal operation");
  endtask

  task automatic t_pfail_clear();
    @(negedge clk); pfail_pulse = 1'b1;
    @(posedge clk); #1 chk(1'b1, "R3 pfail asserts reset next edge");
    @(negedge clk); pfail_pulse = 1'b0;
    send_frame(0, 1'b1); send_frame(1, 1'b1); send_frame(2, 1'b1);
    pulse_pfail();
    send_frame(3, 1'b1);
    repeat (4) @(negedge clk);
    chk(1'b1, "R3 scoreboard cleared by pfail");
    send_frame(0, 1'b1); send_frame(1, 1'b1);
    send_last_timed(2, "R5 release after refill");
  endtask

  task automatic t_repeat_order();
    pulse_pfail();
    send_frame(3, 1'b1); send_frame(3, 1'b1); send_frame(1, 1'b1);
    send_frame(1, 1'b1); send_frame(0, 1'b1);
    repeat (4) @(negedge clk);
    chk(1'b1, "R4 repeats without frame 2");
    send_last_timed(2, "R4 out-of-order set completes");
  endtask

  task automatic t_ext_low_complete();
    @(negedge clk); ext_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    pulse_pfail();
    ext_rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(1'b1, "R3 pfail held regardless of pin");
    ext_rst_n = 1'b0;
    send_frame(0, 1'b1); send_frame(1, 1'b1);
    send_frame(2, 1'b1); send_frame(3, 1'b1);
    repeat (6) @(negedge clk);
    chk(1'b1, "R6 set complete while pin low");
    ext_rst_n = 1'b1;
    expect_change3(1'b1, "R6 release follows pin high");
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_ext_normal();
    t_normal_frames();
    t_pfail_clear();
    t_repeat_order();
    t_ext_low_complete();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule